// File: doc/BRIEF.md
# SDRAM Read Access Scheduler

This block sits between the frame-memory requesters of a video decoder and a four-bank SDRAM. It takes one read or write request at a time, each carrying a bank, a row and a column. It keeps the open row of every bank and sorts each request into one of three classes. A request can hit the open row of its bank, or find a different row open there, or find the bank closed. For each class it issues the shortest legal sequence of PRECHARGE, ACTIVE and column commands on a single shared command and address bus.

Rows are never closed automatically. A row stays open until a request needs another row in the same bank, so a later access to it goes out as a bare column command. Per-bank down-counters enforce the ACTIVE-to-column delay, the precharge period and the minimum row-active time. A global counter spaces column commands one burst apart. The pending register is freed as soon as a column command leaves, which lets the next request's PRECHARGE or ACTIVE go out while the current read burst is still on the data bus. A delay line CL stages deep flags the cycles that carry read data.

Top module: `sdram_rd_sched`

## Requirements
- R1: After reset the command output is NOP, request ready is high and read-data valid is low. Command encoding on cmd_o: 0 NOP, 1 ACTIVE, 2 PRECHARGE, 3 READ, 4 WRITE.
- R2: A request to a closed bank produces ACTIVE and then its column command, no fewer than T_RCD cycles after that ACTIVE. When nothing else blocks, the gap is exactly T_RCD.
- R3: A request to the row already open in its bank produces only a column command, with no PRECHARGE or ACTIVE.
- R4: A request that finds another row open produces PRECHARGE, ACTIVE and the column command, in that order. The ACTIVE comes no fewer than T_RP cycles after the PRECHARGE, and exactly T_RP when nothing else blocks.
- R5: A PRECHARGE to a bank comes no fewer than T_RAS cycles after that bank's last ACTIVE. It is issued exactly then when it is the only thing waiting.
- R6: A column command never closes its row, so a later request to the same row in that bank is a hit.
- R7: Column commands are at least BL cycles apart. Consecutive hits are issued exactly BL cycles apart.
- R8: rd_valid_o is high for exactly BL cycles, starting CL cycles after each READ command.
- R9: WRITE commands never raise rd_valid_o.
- R10: Only one request is held at a time. Ready is low in the cycle after a request is accepted and stays low until that request's column command has gone out. Commands leave in request order.
- R11: cmd_bank_o carries the request bank on every command. cmd_addr_o carries the row on ACTIVE, the column on READ or WRITE, and zero on PRECHARGE.
- R12: A read to a closed bank that directly follows a read to another bank has its ACTIVE issued during the earlier burst. Its READ comes exactly BL cycles after the earlier READ, so the 2*BL data cycles are contiguous.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high together with valid |
| req_write_i | input | 1 | 1 for write, 0 for read |
| req_bank_i | input | BANK_W | Target bank |
| req_row_i | input | ROW_W | Target row |
| req_col_i | input | COL_W | Target column |
| cmd_o | output | 3 | Command issued this cycle |
| cmd_bank_o | output | BANK_W | Bank of the issued command |
| cmd_addr_o | output | ADDR_W | Row or column of the issued command |
| rd_valid_o | output | 1 | Read data on the bus this cycle |

## Verification
The stimulus contains back-to-back reads to two closed banks. This pattern separates a scheduler that hides ACTIVE behind the running burst from one that serialises it. Repeated hits to open rows expose any hidden precharge and show whether the burst spacing is exact. A conflict issued right after a fresh ACTIVE isolates the row-active limit, which is the only thing that can delay that PRECHARGE. A run of writes mixing closed, hit and conflict cases confirms that column writes follow the same ordering and never produce read-valid cycles.

// File: rtl/sdram_sched_pkg.sv
package sdram_sched_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_PRE = 3'd2,
    CMD_RD  = 3'd3,
    CMD_WR  = 3'd4
  } sd_cmd_e;

  typedef enum logic [1:0] {
    CLS_HIT,
    CLS_CONFLICT,
    CLS_CLOSED
  } acc_cls_e;
endpackage

// File: rtl/sdram_bank_state.sv
module sdram_bank_state #(
  parameter int ROW_W = 11,
  parameter int CNT_W = 3,
  parameter int T_RCD = 2,
  parameter int T_RP  = 2,
  parameter int T_RAS = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic             pre_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o,
  output logic             act_ok_o,
  output logic             pre_ok_o,
  output logic             cas_ok_o
);
  logic             open_q;
  logic [ROW_W-1:0] row_q;
  logic [CNT_W-1:0] act_cnt_q, pre_cnt_q, cas_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q    <= 1'b0;
      row_q     <= '0;
      act_cnt_q <= '0;
      pre_cnt_q <= '0;
      cas_cnt_q <= '0;
    end else begin
      if (act_i) begin
        open_q <= 1'b1;
        row_q  <= row_i;
      end else if (pre_i) begin
        open_q <= 1'b0;
      end
      // counters hold cycles remaining until the next command class is legal
      if (pre_i)                act_cnt_q <= CNT_W'(T_RP - 1);
      else if (act_cnt_q != '0) act_cnt_q <= act_cnt_q - 1'b1;
      if (act_i)                pre_cnt_q <= CNT_W'(T_RAS - 1);
      else if (pre_cnt_q != '0) pre_cnt_q <= pre_cnt_q - 1'b1;
      if (act_i)                cas_cnt_q <= CNT_W'(T_RCD - 1);
      else if (cas_cnt_q != '0) cas_cnt_q <= cas_cnt_q - 1'b1;
    end
  end

  assign open_o   = open_q;
  assign row_o    = row_q;
  assign act_ok_o = !open_q && (act_cnt_q == '0);
  assign pre_ok_o = open_q && (pre_cnt_q == '0);
  assign cas_ok_o = open_q && (cas_cnt_q == '0);
endmodule

// File: rtl/sdram_cmd_pick.sv
module sdram_cmd_pick import sdram_sched_pkg::*; #(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2,
  parameter int ROW_W     = 11,
  parameter int COL_W     = 8,
  parameter int ADDR_W    = 11
) (
  input  logic                             pend_valid_i,
  input  logic                             pend_write_i,
  input  logic [BANK_W-1:0]                pend_bank_i,
  input  logic [ROW_W-1:0]                 pend_row_i,
  input  logic [COL_W-1:0]                 pend_col_i,
  input  logic [NUM_BANKS-1:0]             bank_open_i,
  input  logic [NUM_BANKS-1:0][ROW_W-1:0]  open_row_i,
  input  logic [NUM_BANKS-1:0]             act_ok_i,
  input  logic [NUM_BANKS-1:0]             pre_ok_i,
  input  logic [NUM_BANKS-1:0]             cas_ok_i,
  input  logic                             burst_ok_i,
  output sd_cmd_e                          cmd_o,
  output logic [BANK_W-1:0]                cmd_bank_o,
  output logic [ADDR_W-1:0]                cmd_addr_o,
  output logic                             col_done_o
);
  acc_cls_e cls;

  always_comb begin
    cls = CLS_CLOSED;
    if (bank_open_i[pend_bank_i])
      cls = (open_row_i[pend_bank_i] == pend_row_i) ? CLS_HIT : CLS_CONFLICT;
  end

  always_comb begin
    cmd_o      = CMD_NOP;
    cmd_addr_o = '0;
    col_done_o = 1'b0;
    if (pend_valid_i) begin
      unique case (cls)
        CLS_HIT: begin
          if (cas_ok_i[pend_bank_i] && burst_ok_i) begin
            cmd_o      = pend_write_i ? CMD_WR : CMD_RD;
            cmd_addr_o = ADDR_W'(pend_col_i);
            col_done_o = 1'b1;
          end
        end
        CLS_CONFLICT: begin
          if (pre_ok_i[pend_bank_i]) cmd_o = CMD_PRE;
        end
        default: begin
          if (act_ok_i[pend_bank_i]) begin
            cmd_o      = CMD_ACT;
            cmd_addr_o = ADDR_W'(pend_row_i);
          end
        end
      endcase
    end
  end

  assign cmd_bank_o = pend_bank_i;
endmodule

// File: rtl/sdram_rd_valid.sv
module sdram_rd_valid #(
  parameter int CL = 2,
  parameter int BL = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_issue_i,
  output logic rd_valid_o
);
  localparam int REM_W = $clog2(BL + 1);

  logic [CL-1:0]    stage_q;
  logic [REM_W-1:0] rem_q;

  generate
    if (CL == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q <= '0;
        else         stage_q <= rd_issue_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q <= '0;
        else         stage_q <= {stage_q[CL-2:0], rd_issue_i};
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rem_q <= '0;
    else if (stage_q[CL-1])   rem_q <= REM_W'(BL - 1);
    else if (rem_q != '0)     rem_q <= rem_q - 1'b1;
  end

  assign rd_valid_o = stage_q[CL-1] || (rem_q != '0);
endmodule

// File: rtl/sdram_rd_sched.sv
module sdram_rd_sched import sdram_sched_pkg::*; #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 11,
  parameter int COL_W     = 8,
  parameter int T_RCD     = 2,
  parameter int T_RP      = 2,
  parameter int T_RAS     = 5,
  parameter int CL        = 2,
  parameter int BL        = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int ADDR_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic [COL_W-1:0]  req_col_i,
  output logic [2:0]        cmd_o,
  output logic [BANK_W-1:0] cmd_bank_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic              rd_valid_o
);
  localparam int T_HI  = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int T_MAX = (T_RAS > T_HI) ? T_RAS : T_HI;
  localparam int CNT_W = $clog2(T_MAX + 1);
  localparam int BST_W = $clog2(BL + 1);

  logic              pend_valid_q, pend_write_q;
  logic [BANK_W-1:0] pend_bank_q;
  logic [ROW_W-1:0]  pend_row_q;
  logic [COL_W-1:0]  pend_col_q;
  logic [BST_W-1:0]  burst_cnt_q;
  logic              col_done, accept;
  sd_cmd_e           cmd;

  logic [NUM_BANKS-1:0]            bank_open, act_ok, pre_ok, cas_ok;
  logic [NUM_BANKS-1:0][ROW_W-1:0] open_row;

  assign req_ready_o = !pend_valid_q;
  assign accept      = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_valid_q <= 1'b0;
      pend_write_q <= 1'b0;
      pend_bank_q  <= '0;
      pend_row_q   <= '0;
      pend_col_q   <= '0;
    end else if (accept) begin
      pend_valid_q <= 1'b1;
      pend_write_q <= req_write_i;
      pend_bank_q  <= req_bank_i;
      pend_row_q   <= req_row_i;
      pend_col_q   <= req_col_i;
    end else if (col_done) begin
      pend_valid_q <= 1'b0;
    end
  end

  // data-bus occupancy: next column command waits one burst
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                burst_cnt_q <= '0;
    else if (col_done)          burst_cnt_q <= BST_W'(BL - 1);
    else if (burst_cnt_q != '0) burst_cnt_q <= burst_cnt_q - 1'b1;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit_bank;
    assign hit_bank = (pend_bank_q == BANK_W'(b));
    sdram_bank_state #(
      .ROW_W (ROW_W), .CNT_W (CNT_W),
      .T_RCD (T_RCD), .T_RP (T_RP), .T_RAS (T_RAS)
    ) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .act_i    (hit_bank && (cmd == CMD_ACT)),
      .pre_i    (hit_bank && (cmd == CMD_PRE)),
      .row_i    (pend_row_q),
      .open_o   (bank_open[b]),
      .row_o    (open_row[b]),
      .act_ok_o (act_ok[b]),
      .pre_ok_o (pre_ok[b]),
      .cas_ok_o (cas_ok[b])
    );
  end

  sdram_cmd_pick #(
    .NUM_BANKS (NUM_BANKS), .BANK_W (BANK_W),
    .ROW_W (ROW_W), .COL_W (COL_W), .ADDR_W (ADDR_W)
  ) u_pick (
    .pend_valid_i (pend_valid_q),
    .pend_write_i (pend_write_q),
    .pend_bank_i  (pend_bank_q),
    .pend_row_i   (pend_row_q),
    .pend_col_i   (pend_col_q),
    .bank_open_i  (bank_open),
    .open_row_i   (open_row),
    .act_ok_i     (act_ok),
    .pre_ok_i     (pre_ok),
    .cas_ok_i     (cas_ok),
    .burst_ok_i   (burst_cnt_q == '0),
    .cmd_o        (cmd),
    .cmd_bank_o   (cmd_bank_o),
    .cmd_addr_o   (cmd_addr_o),
    .col_done_o   (col_done)
  );

  sdram_rd_valid #(.CL (CL), .BL (BL)) u_rdv (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_issue_i (cmd == CMD_RD),
    .rd_valid_o (rd_valid_o)
  );

  assign cmd_o = cmd;
endmodule

// File: rtl/sdram_rd_sched_chk.sv
module sdram_rd_sched_chk #(
  parameter int NUM_BANKS = 4,
  parameter int T_RCD     = 2,
  parameter int T_RP      = 2,
  parameter int T_RAS     = 5,
  parameter int CL        = 2,
  parameter int BL        = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_i,
  input logic [2:0]        cmd_i,
  input logic [BANK_W-1:0] cmd_bank_i,
  input logic              rd_valid_i
);
  localparam int SW = 16;

  logic          col_cmd;
  logic [SW-1:0] since_col;
  assign col_cmd = (cmd_i == 3'd3) || (cmd_i == 3'd4);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              since_col <= '1;
    else if (col_cmd)         since_col <= SW'(1);
    else if (since_col != '1) since_col <= since_col + 1'b1;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic          act_b, pre_b, col_b;
    logic [SW-1:0] since_act, since_pre;
    assign act_b = (cmd_i == 3'd1) && (cmd_bank_i == BANK_W'(b));
    assign pre_b = (cmd_i == 3'd2) && (cmd_bank_i == BANK_W'(b));
    assign col_b = col_cmd && (cmd_bank_i == BANK_W'(b));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        since_act <= '1;
        since_pre <= '1;
      end else begin
        if (act_b)                 since_act <= SW'(1);
        else if (since_act != '1)  since_act <= since_act + 1'b1;
        if (pre_b)                 since_pre <= SW'(1);
        else if (since_pre != '1)  since_pre <= since_pre + 1'b1;
      end
    end

    // R2
    rcd_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      col_b |-> since_act >= SW'(T_RCD));
    // R4
    rp_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      act_b |-> since_pre >= SW'(T_RP));
    // R5
    ras_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pre_b |-> since_act >= SW'(T_RAS));
  end

  // R7
  burst_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_cmd |-> since_col >= SW'(BL));
  // R8
  rd_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_valid_i) |-> ($past(cmd_i, CL) == 3'd3));
  // R10
  single_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_i) |=> !req_ready_i);
endmodule

bind sdram_rd_sched sdram_rd_sched_chk #(
  .NUM_BANKS (NUM_BANKS), .T_RCD (T_RCD), .T_RP (T_RP),
  .T_RAS (T_RAS), .CL (CL), .BL (BL)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_i (req_ready_o),
  .cmd_i       (cmd_o),
  .cmd_bank_i  (cmd_bank_o),
  .rd_valid_i  (rd_valid_o)
);

// File: tb/sdram_rd_sched_bench.sv
module sdram_rd_sched_bench;
  localparam int NB = 4, ROW_W = 11, COL_W = 8;
  localparam int T_RCD = 2, T_RP = 2, T_RAS = 5, CL = 2, BL = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_bank = '0;
  logic [10:0] req_row = '0;
  logic [7:0]  req_col = '0;
  logic        req_ready, rd_valid;
  logic [2:0]  cmd;
  logic [1:0]  cmd_bank;
  logic [10:0] cmd_addr;

  always #4 clk = ~clk;

  sdram_rd_sched #(
    .NUM_BANKS (NB), .ROW_W (ROW_W), .COL_W (COL_W),
    .T_RCD (T_RCD), .T_RP (T_RP), .T_RAS (T_RAS), .CL (CL), .BL (BL)
  ) u_sdram_rd_sched (
    .clk_i (clk), .rst_ni (rst_n),
    .req_valid_i (req_valid), .req_ready_o (req_ready),
    .req_write_i (req_write), .req_bank_i (req_bank),
    .req_row_i (req_row), .req_col_i (req_col),
    .cmd_o (cmd), .cmd_bank_o (cmd_bank), .cmd_addr_o (cmd_addr),
    .rd_valid_o (rd_valid)
  );

  typedef struct { int c; int bank; int addr; } exp_t;
  exp_t exp_q[$];
  exp_t got;
  int   open_row [NB];
  int   last_act [NB], prev_act [NB], last_pre [NB];
  int   last_col = -1000, prev_col = -1000, last_rd = -1000, prev_rd = -1000;
  int   cyc = 0, rv_seen = 0, compared = 0, mismatched = 0;
  bit   started = 0, done = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push(int c, int b, int a);
    exp_t e;
    e.c = c; e.bank = b; e.addr = a;
    exp_q.push_back(e);
  endtask

  // expected command stream from the open-row model; called at a negedge
  task automatic send(bit wr, int bank, int row, int col);
    int cc = wr ? 4 : 3;
    if (open_row[bank] == row) push(cc, bank, col);
    else begin
      if (open_row[bank] != -1) push(2, bank, 0);
      push(1, bank, row);
      push(cc, bank, col);
      open_row[bank] = row;
    end
    req_valid = 1'b1; req_write = wr;
    req_bank = 2'(bank); req_row = 11'(row); req_col = 8'(col);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R10", "ready after accept", int'(req_ready), 0);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (10) @(negedge clk);
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && started && !done) begin
      bit exp_rv;
      int b;
      cyc++;
      exp_rv = ((cyc - last_rd) >= CL && (cyc - last_rd) < CL + BL) ||
               ((cyc - prev_rd) >= CL && (cyc - prev_rd) < CL + BL);
      check(rd_valid == exp_rv, "R8", "rd_valid", int'(rd_valid), int'(exp_rv));
      if (rd_valid) rv_seen++;
      if (cmd != 3'd0) begin
        b = int'(cmd_bank);
        if (exp_q.size() == 0) begin
          check(1'b0, "R10", "unexpected command", int'(cmd), 0);
        end else begin
          got = exp_q.pop_front();
          check(int'(cmd) == got.c, "R3", "command", int'(cmd), got.c);
          check(b == got.bank, "R11", "bank", b, got.bank);
          check(int'(cmd_addr) == got.addr, "R11", "address", int'(cmd_addr), got.addr);
        end
        case (cmd)
          3'd1: begin
            check(cyc - last_pre[b] >= T_RP, "R4", "PRE to ACT gap", cyc - last_pre[b], T_RP);
            prev_act[b] = last_act[b];
            last_act[b] = cyc;
          end
          3'd2: begin
            check(cyc - last_act[b] >= T_RAS, "R5", "ACT to PRE gap", cyc - last_act[b], T_RAS);
            last_pre[b] = cyc;
          end
          default: begin
            check(cyc - last_act[b] >= T_RCD, "R2", "ACT to column gap", cyc - last_act[b], T_RCD);
            check(cyc - last_col >= BL, "R7", "column spacing", cyc - last_col, BL);
            prev_col = last_col;
            last_col = cyc;
            if (cmd == 3'd3) begin
              prev_rd = last_rd;
              last_rd = cyc;
            end
          end
        endcase
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "R10", "watchdog expired", cyc, 0);
    done = 1;
    report();
  end

  initial begin
    int rv_before;
    for (int i = 0; i < NB; i++) begin
      open_row[i] = -1; last_act[i] = -1000; prev_act[i] = -1000; last_pre[i] = -1000;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd == 3'd0, "R1", "cmd after reset", int'(cmd), 0);
    check(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);
    check(rd_valid == 1'b0, "R1", "rd_valid after reset", int'(rd_valid), 0);
    started = 1;
    @(negedge clk);

    // R12: two reads to closed banks, second ACT hidden behind first burst
    send(0, 0, 5, 1);
    send(0, 1, 7, 2);
    drain();
    check(last_col - prev_col == BL, "R12", "READ to READ gap", last_col - prev_col, BL);
    check(last_col - last_act[1] == T_RCD, "R2", "ACT to READ gap", last_col - last_act[1], T_RCD);

    // R3 R6: hits on rows left open
    send(0, 0, 5, 9);
    send(0, 1, 7, 3);
    drain();
    check(last_col - prev_col == BL, "R7", "hit to hit gap", last_col - prev_col, BL);

    // R5: conflict right after a fresh ACTIVE waits for row-active time
    send(0, 2, 1, 0);
    send(0, 2, 2, 4);
    drain();
    check(last_pre[2] - prev_act[2] == T_RAS, "R5", "ACT to PRE exact", last_pre[2] - prev_act[2], T_RAS);
    check(last_act[2] - last_pre[2] == T_RP, "R4", "PRE to ACT exact", last_act[2] - last_pre[2], T_RP);
    check(last_col - last_act[2] == T_RCD, "R2", "ACT to READ exact", last_col - last_act[2], T_RCD);

    // R9: writes across closed, hit and conflict cases
    rv_before = rv_seen;
    send(1, 3, 9, 5);
    send(1, 3, 9, 6);
    send(1, 0, 6, 2);
    drain();
    check(rv_seen == rv_before, "R9", "rd_valid cycles during writes", rv_seen - rv_before, 0);

    // R6: read hits after writes
    send(0, 3, 9, 7);
    send(0, 1, 7, 3);
    drain();
    check(exp_q.size() == 0, "R10", "commands outstanding", exp_q.size(), 0);
    done = 1;
    report();
  end
endmodule